// File: doc/BRIEF.md
# Double-Clocked TDM PCM Serial Port

This block is a four-channel time-division-multiplexed PCM serial port. Its bit clock toggles twice per data bit, so every 8-bit sample occupies a 16-cycle time slot on the serial lines. A frame sync pulse sets the frame reference once per frame, typically every 125 µs. Frame lengths from 4 to 128 slots are covered.

Each channel owns a transmit slot and a receive slot. It also has its own transmit and receive skew of 0 to 7 bit-clock cycles. On transmit, the port drives one channel's sample MSB first onto a single data line. A line-enable output marks when the line is driven, and an active-low strobe on the channel's selected bus marks the same window. On receive, the port samples the data line on every second falling edge inside each assigned slot. The finished byte is kept in a per-channel holding register, and a one-cycle valid pulse announces it.

A single write port programs a channel's settings. The same port can also load identical settings into all channels at once.

The port runs directly on the bit clock. Transmit and strobe outputs change on rising edges; frame sync reference and receive capture use falling edges.

Top module: `pcm_dc_port`

## Requirements
- R1: While rst_ni is low, dx_oe_o is 0, tx_strobe_n_o is all ones, rx_valid_o is 0 and rx_data_o is 0; all channels are disabled with slot 0 and skew 0.
- R2: A frame starts only where fs_i is seen high after being seen low. Holding fs_i high for several cycles does not restart the frame, and no slot activity occurs before the first frame start after reset.
- R3: Transmit bits go out MSB first, each held for two bit-clock cycles. With zero skew, the MSB appears after the rising edge at which fs_i is first seen high, ahead of the falling edge that samples it.
- R4: A transmit skew of t (0..7) delays the channel's whole transmit window by t bit-clock cycles; a receive skew of r (0..7) delays every receive capture by r cycles; the two are independent.
- R5: With zero skew, the receive MSB is captured on the falling edge after the first falling edge that sees fs_i high. Later bits are captured on every second falling edge, and the falling edges in between are ignored. Slot s starts 16·s cycles later.
- R6: On the falling edge that captures a slot's last bit, rx_valid_o[c] pulses high for one cycle and the byte appears on rx_data_o[8c+7:8c]; it holds until that channel's next slot completes.
- R7: The strobe bit selected by the driving channel's bus setting (bit b for bus b) is low exactly while dx_oe_o is high, and at most one strobe bit is low.
- R8: dx_oe_o is 0 in every cycle not covered by an enabled channel's transmit window; disabled channels neither drive nor capture.
- R9: When several enabled channels cover the same transmit cycle, the lowest-numbered one drives dx_o and selects the strobe; channels sharing a receive slot all capture it.
- R10: A write with cfg_bcast_i high loads the presented settings into every channel regardless of cfg_ch_i; without it only channel cfg_ch_i changes.
- R11: Slot numbers 0..127 are accepted; slot 127 with skew 7 completes within a 2064-cycle frame.
- R12: Each channel's transmit byte is taken from tx_data_i[8c+7:8c] at the rising edge that starts the frame; later changes within the frame do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, two cycles per data bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fs_i | input | 1 | Frame sync, synchronous to clk_i |
| cfg_we_i | input | 1 | Settings write strobe |
| cfg_bcast_i | input | 1 | Write all channels at once |
| cfg_ch_i | input | 2 | Target channel for a single write |
| cfg_tx_en_i | input | 1 | Transmit enable to write |
| cfg_rx_en_i | input | 1 | Receive enable to write |
| cfg_tx_slot_i | input | 7 | Transmit slot to write |
| cfg_rx_slot_i | input | 7 | Receive slot to write |
| cfg_tx_skew_i | input | 3 | Transmit skew in bit-clock cycles |
| cfg_rx_skew_i | input | 3 | Receive skew in bit-clock cycles |
| cfg_tx_bus_i | input | 1 | Strobe bus the channel uses |
| tx_data_i | input | 32 | Transmit bytes, channel c at bits 8c+7..8c |
| dx_o | output | 1 | Serial transmit data |
| dx_oe_o | output | 1 | Transmit line drive enable |
| tx_strobe_n_o | output | 2 | Active-low slot strobe per bus |
| dr_i | input | 1 | Serial receive data |
| rx_data_o | output | 32 | Received bytes, channel c at bits 8c+7..8c |
| rx_valid_o | output | 4 | One-cycle receive completion pulse per channel |

## Verification
The assertions assume three things about the inputs: fs_i changes only between clock edges, each frame has one rising edge of fs_i, and a frame is long enough that every enabled slot finishes before the next sync. Under these assumptions, the valid pulses stay one cycle wide, held bytes change only on a completion, and the strobes track the line enable. The stimulus drives fs_i, dr_i and tx_data_i a few nanoseconds after a clock edge. It uses 2064-cycle frames, which cover slot 127 with skew 7. It performs settings writes only while no frame is in progress, so no window is retimed mid-slot.

// File: rtl/pcm_dc_pkg.sv
`timescale 1ns/1ps
package pcm_dc_pkg;
  localparam int SLOT_W    = 7;
  localparam int SKEW_W    = 3;
  localparam int NUM_BUS   = 2;
  localparam int BUS_W     = 1;
  localparam int MAX_SLOTS = 1 << SLOT_W;

  typedef struct packed {
    logic              en;
    logic [SLOT_W-1:0] slot;
    logic [SKEW_W-1:0] skew;
    logic [BUS_W-1:0]  bus;
  } tx_cfg_t;

  typedef struct packed {
    logic              en;
    logic [SLOT_W-1:0] slot;
    logic [SKEW_W-1:0] skew;
  } rx_cfg_t;
endpackage

// File: rtl/pcm_dc_cfg.sv
`timescale 1ns/1ps
module pcm_dc_cfg
  import pcm_dc_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            bcast_i,
  input  logic [CH_W-1:0] ch_i,
  input  tx_cfg_t         tx_wr_i,
  input  rx_cfg_t         rx_wr_i,
  output tx_cfg_t         tx_cfg_o [NUM_CH],
  output rx_cfg_t         rx_cfg_o [NUM_CH]
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic    sel;
    tx_cfg_t tx_q;
    rx_cfg_t rx_q;
    assign sel = we_i && (bcast_i || ch_i == CH_W'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tx_q <= '0;
        rx_q <= '0;
      end else if (sel) begin
        tx_q <= tx_wr_i;
        rx_q <= rx_wr_i;
      end
    end
    assign tx_cfg_o[c] = tx_q;
    assign rx_cfg_o[c] = rx_q;
  end
endmodule

// File: rtl/pcm_dc_tx.sv
`timescale 1ns/1ps
module pcm_dc_tx
  import pcm_dc_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 8,
  parameter int CNT_W    = 12,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SPAN    = 2 * SAMPLE_W,
  localparam int BI_W    = $clog2(SAMPLE_W)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         fs_i,
  input  tx_cfg_t                      cfg_i [NUM_CH],
  input  logic [NUM_CH*SAMPLE_W-1:0]   data_i,
  output logic                         dx_o,
  output logic                         dx_oe_o,
  output logic [NUM_BUS-1:0]           strobe_n_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [BI_W-1:0]  BI_TOP  = BI_W'(SAMPLE_W - 1);

  logic             fs_q, start;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [NUM_CH-1:0] hit, bitv;

  // frame reference: fs first seen high on a rising edge
  assign start = fs_i && !fs_q;
  assign cnt_n = start ? '0 : ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SAMPLE_W-1:0] smp_q, smp;
    logic [CNT_W-1:0]    base, rel;
    logic [BI_W-1:0]     bi;
    assign smp  = start ? data_i[c*SAMPLE_W +: SAMPLE_W] : smp_q;
    assign base = CNT_W'(cfg_i[c].slot) * CNT_W'(SPAN) + CNT_W'(cfg_i[c].skew);
    assign rel  = cnt_n - base;
    assign hit[c]  = cfg_i[c].en && (cnt_n >= base) && (rel < CNT_W'(SPAN));
    assign bi      = rel[BI_W:1];
    assign bitv[c] = smp[BI_TOP - bi];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    smp_q <= '0;
      else if (start) smp_q <= data_i[c*SAMPLE_W +: SAMPLE_W];
    end
  end

  logic            own_hit;
  logic [CH_W-1:0] own;
  always_comb begin
    own_hit = 1'b0;
    own     = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (hit[c]) begin
        own_hit = 1'b1;
        own     = CH_W'(c);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q       <= 1'b0;
      cnt_q      <= CNT_MAX;
      dx_o       <= 1'b0;
      dx_oe_o    <= 1'b0;
      strobe_n_o <= '1;
    end else begin
      fs_q       <= fs_i;
      cnt_q      <= cnt_n;
      dx_oe_o    <= own_hit;
      dx_o       <= own_hit && bitv[own];
      strobe_n_o <= '1;
      if (own_hit) strobe_n_o[cfg_i[own].bus] <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_dc_rx.sv
`timescale 1ns/1ps
module pcm_dc_rx
  import pcm_dc_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 8,
  parameter int CNT_W    = 12,
  localparam int SPAN    = 2 * SAMPLE_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fs_i,
  input  rx_cfg_t                    cfg_i [NUM_CH],
  input  logic                       dr_i,
  output logic [NUM_CH*SAMPLE_W-1:0] data_o,
  output logic [NUM_CH-1:0]          valid_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             fs_q, start;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign start = fs_i && !fs_q;
  assign cnt_n = start ? '0 : ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1);

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q  <= 1'b0;
      cnt_q <= CNT_MAX;
    end else begin
      fs_q  <= fs_i;
      cnt_q <= cnt_n;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CNT_W-1:0]    base, rel;
    logic                win, take, last;
    logic [SAMPLE_W-2:0] sh_q;
    logic [SAMPLE_W-1:0] data_q;
    logic                valid_q;
    // MSB lands one falling edge after the reference edge
    assign base = CNT_W'(cfg_i[c].slot) * CNT_W'(SPAN) + CNT_W'(cfg_i[c].skew) + 1'b1;
    assign rel  = cnt_n - base;
    assign win  = cfg_i[c].en && (cnt_n >= base) && (rel < CNT_W'(SPAN));
    assign take = win && !rel[0];
    assign last = win && (rel == CNT_W'(SPAN - 2));
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q    <= '0;
        data_q  <= '0;
        valid_q <= 1'b0;
      end else begin
        valid_q <= last;
        if (take) sh_q   <= {sh_q[SAMPLE_W-3:0], dr_i};
        if (last) data_q <= {sh_q, dr_i};
      end
    end
    assign data_o[c*SAMPLE_W +: SAMPLE_W] = data_q;
    assign valid_o[c] = valid_q;
  end
endmodule

// File: rtl/pcm_dc_port.sv
`timescale 1ns/1ps
module pcm_dc_port
  import pcm_dc_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 8,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SPAN    = 2 * SAMPLE_W,
  localparam int CNT_W   = $clog2(MAX_SLOTS * SPAN + SPAN + (1 << SKEW_W) + 2)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fs_i,
  input  logic                       cfg_we_i,
  input  logic                       cfg_bcast_i,
  input  logic [CH_W-1:0]            cfg_ch_i,
  input  logic                       cfg_tx_en_i,
  input  logic                       cfg_rx_en_i,
  input  logic [SLOT_W-1:0]          cfg_tx_slot_i,
  input  logic [SLOT_W-1:0]          cfg_rx_slot_i,
  input  logic [SKEW_W-1:0]          cfg_tx_skew_i,
  input  logic [SKEW_W-1:0]          cfg_rx_skew_i,
  input  logic [BUS_W-1:0]           cfg_tx_bus_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] tx_data_i,
  output logic                       dx_o,
  output logic                       dx_oe_o,
  output logic [NUM_BUS-1:0]         tx_strobe_n_o,
  input  logic                       dr_i,
  output logic [NUM_CH*SAMPLE_W-1:0] rx_data_o,
  output logic [NUM_CH-1:0]          rx_valid_o
);
  tx_cfg_t tx_wr;
  rx_cfg_t rx_wr;
  tx_cfg_t tx_cfg [NUM_CH];
  rx_cfg_t rx_cfg [NUM_CH];

  always_comb begin
    tx_wr.en   = cfg_tx_en_i;
    tx_wr.slot = cfg_tx_slot_i;
    tx_wr.skew = cfg_tx_skew_i;
    tx_wr.bus  = cfg_tx_bus_i;
    rx_wr.en   = cfg_rx_en_i;
    rx_wr.slot = cfg_rx_slot_i;
    rx_wr.skew = cfg_rx_skew_i;
  end

  pcm_dc_cfg #(.NUM_CH(NUM_CH)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .bcast_i  (cfg_bcast_i),
    .ch_i     (cfg_ch_i),
    .tx_wr_i  (tx_wr),
    .rx_wr_i  (rx_wr),
    .tx_cfg_o (tx_cfg),
    .rx_cfg_o (rx_cfg)
  );

  pcm_dc_tx #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fs_i       (fs_i),
    .cfg_i      (tx_cfg),
    .data_i     (tx_data_i),
    .dx_o       (dx_o),
    .dx_oe_o    (dx_oe_o),
    .strobe_n_o (tx_strobe_n_o)
  );

  pcm_dc_rx #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fs_i    (fs_i),
    .cfg_i   (rx_cfg),
    .dr_i    (dr_i),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o)
  );
endmodule

// File: rtl/pcm_dc_port_chk.sv
`timescale 1ns/1ps
module pcm_dc_port_chk
  import pcm_dc_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       dx_oe_o,
  input logic [NUM_BUS-1:0]         tx_strobe_n_o,
  input logic [NUM_CH*SAMPLE_W-1:0] rx_data_o,
  input logic [NUM_CH-1:0]          rx_valid_o
);
  assert_strobe_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~tx_strobe_n_o));

  assert_strobe_tracks_oe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dx_oe_o == ($countones(~tx_strobe_n_o) == 1));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assert_valid_pulse_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
      rx_valid_o[c] |=> !rx_valid_o[c]);

    assert_data_hold_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
      !$stable(rx_data_o[c*SAMPLE_W +: SAMPLE_W]) |-> rx_valid_o[c]);
  end
endmodule

bind pcm_dc_port pcm_dc_port_chk #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .dx_oe_o       (dx_oe_o),
  .tx_strobe_n_o (tx_strobe_n_o),
  .rx_data_o     (rx_data_o),
  .rx_valid_o    (rx_valid_o)
);

// File: tb/pcm_dc_port_tb_top.sv
`timescale 1ns/1ps
module pcm_dc_port_tb_top;
  localparam int NCH   = 4;
  localparam int SW    = 8;
  localparam int FRAME = 2064;

  logic clk = 1'b0;
  logic rst_ni;
  logic fs = 1'b0, dr = 1'b1;
  logic cfg_we = 1'b0, cfg_bcast = 1'b0;
  logic [1:0] cfg_ch = '0;
  logic cfg_tx_en = 1'b0, cfg_rx_en = 1'b0;
  logic [6:0] cfg_tx_slot = '0, cfg_rx_slot = '0;
  logic [2:0] cfg_tx_skew = '0, cfg_rx_skew = '0;
  logic [0:0] cfg_tx_bus = '0;
  logic [NCH*SW-1:0] tx_data = '0;
  logic dx_o, dx_oe_o;
  logic [1:0] tx_strobe_n_o;
  logic [NCH*SW-1:0] rx_data_o;
  logic [NCH-1:0] rx_valid_o;

  always #10 clk = ~clk;

  pcm_dc_port #(.NUM_CH(NCH), .SAMPLE_W(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .fs_i(fs),
    .cfg_we_i(cfg_we), .cfg_bcast_i(cfg_bcast), .cfg_ch_i(cfg_ch),
    .cfg_tx_en_i(cfg_tx_en), .cfg_rx_en_i(cfg_rx_en),
    .cfg_tx_slot_i(cfg_tx_slot), .cfg_rx_slot_i(cfg_rx_slot),
    .cfg_tx_skew_i(cfg_tx_skew), .cfg_rx_skew_i(cfg_rx_skew),
    .cfg_tx_bus_i(cfg_tx_bus), .tx_data_i(tx_data),
    .dx_o(dx_o), .dx_oe_o(dx_oe_o), .tx_strobe_n_o(tx_strobe_n_o),
    .dr_i(dr), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
  );

  // {ch, tx slot, tx skew, rx slot, rx skew, bus, tx byte, rx byte}
  localparam logic [38:0] VEC [6] = '{
    {2'd0, 7'd0,   3'd0, 7'd0,   3'd0, 1'b0, 8'hA5, 8'h3C},
    {2'd1, 7'd2,   3'd3, 7'd5,   3'd1, 1'b1, 8'h81, 8'h7E},
    {2'd2, 7'd7,   3'd7, 7'd3,   3'd6, 1'b0, 8'hFF, 8'h00},
    {2'd3, 7'd127, 3'd7, 7'd127, 3'd7, 1'b1, 8'h5A, 8'hC3},
    {2'd0, 7'd31,  3'd5, 7'd0,   3'd2, 1'b1, 8'h01, 8'h80},
    {2'd2, 7'd1,   3'd0, 7'd1,   3'd7, 1'b1, 8'h6B, 8'hD4}
  };

  int n_checks = 0, n_errors = 0;
  bit done = 1'b0;

  bit       m_te [NCH], m_re [NCH];
  int       m_ts [NCH], m_to [NCH], m_rs [NCH], m_ro [NCH], m_bus [NCH];
  bit [7:0] m_txb [NCH], m_rxb [NCH], held [NCH];

  task automatic chk(string req, string ctx, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s (%s) at %0t: got %0h expected %0h", req, ctx, $time, act, exp);
    end
  endtask

  task automatic cfg_write(bit bc, int ch, bit te, bit re, int ts, int to,
                           int rs, int ro, int bus);
    @(negedge clk); #1;
    cfg_bcast = bc; cfg_ch = 2'(ch);
    cfg_tx_en = te; cfg_rx_en = re;
    cfg_tx_slot = 7'(ts); cfg_tx_skew = 3'(to);
    cfg_rx_slot = 7'(rs); cfg_rx_skew = 3'(ro);
    cfg_tx_bus = 1'(bus);
    cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (bc || c == ch) begin
        m_te[c] = te; m_re[c] = re; m_ts[c] = ts; m_to[c] = to;
        m_rs[c] = rs; m_ro[c] = ro; m_bus[c] = bus;
      end
    end
  endtask

  function automatic int tx_base(int c);
    return m_ts[c] * 2 * SW + m_to[c];
  endfunction

  function automatic int rx_base(int c);
    return m_rs[c] * 2 * SW + m_ro[c] + 1;
  endfunction

  function automatic int tx_owner(int k);
    for (int c = 0; c < NCH; c++)
      if (m_te[c] && k >= tx_base(c) && k < tx_base(c) + 2 * SW) return c;
    return -1;
  endfunction

  // line level before falling edge k; odd edges carry the inverse as a decoy
  function automatic logic rx_line(int k);
    for (int c = 0; c < NCH; c++) begin
      int rel = k - rx_base(c);
      if (m_re[c] && rel >= 0 && rel < 2 * SW) begin
        logic b = m_rxb[c][SW-1-rel/2];
        return (rel % 2 == 0) ? b : ~b;
      end
    end
    return 1'b1;
  endfunction

  task automatic run_frame(string ctx, int fs_len, int flip_k);
    for (int c = 0; c < NCH; c++) tx_data[c*SW +: SW] = m_txb[c];
    @(negedge clk); #1;
    fs = 1'b1;
    for (int k = 0; k < FRAME; k++) begin
      int own;
      @(posedge clk); #2;
      own = tx_owner(k);
      chk("R8", ctx, int'(dx_oe_o), int'(own >= 0));
      if (own >= 0) begin
        int rel = k - tx_base(own);
        chk("R3", ctx, int'(dx_o), int'(m_txb[own][SW-1-rel/2]));
        chk("R7", ctx, int'(tx_strobe_n_o), 3 ^ (1 << m_bus[own]));
      end else begin
        chk("R7", ctx, int'(tx_strobe_n_o), 3);
      end
      if (k == flip_k) tx_data = ~tx_data;
      dr = rx_line(k);
      @(negedge clk); #2;
      for (int c = 0; c < NCH; c++) begin
        bit ev = m_re[c] && (k == rx_base(c) + 2 * SW - 2);
        chk("R6", ctx, int'(rx_valid_o[c]), int'(ev));
        if (ev) held[c] = m_rxb[c];
        chk("R5", ctx, int'(rx_data_o[c*SW +: SW]), int'(held[c]));
      end
      if (k == fs_len - 1) fs = 1'b0;
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_te[c] = 0; m_re[c] = 0; m_ts[c] = 0; m_to[c] = 0;
      m_rs[c] = 0; m_ro[c] = 0; m_bus[c] = 0;
      m_txb[c] = '0; m_rxb[c] = '0; held[c] = '0;
    end
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1", "reset", int'(dx_oe_o), 0);
    chk("R1", "reset", int'(tx_strobe_n_o), 3);
    chk("R1", "reset", int'(rx_valid_o), 0);
    chk("R1", "reset", int'(rx_data_o), 0);
    @(negedge clk); #3 rst_ni = 1'b1;

    // R2: enabled channel stays idle until a frame starts
    cfg_write(1'b0, 0, 1'b1, 1'b1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #2;
      chk("R2", "no sync yet", int'(dx_oe_o), 0);
      chk("R2", "no sync yet", int'(tx_strobe_n_o), 3);
    end

    // R4 R11: table of single-channel settings
    for (int i = 0; i < 6; i++) begin
      logic [38:0] v = VEC[i];
      cfg_write(1'b1, 0, 1'b0, 1'b0, 0, 0, 0, 0, 0);
      cfg_write(1'b0, int'(v[38:37]), 1'b1, 1'b1, int'(v[36:30]), int'(v[29:27]),
                int'(v[26:20]), int'(v[19:17]), int'(v[16]));
      m_txb[v[38:37]] = v[15:8];
      m_rxb[v[38:37]] = v[7:0];
      run_frame("R4 R11 vector", 1, -1);
    end

    // R9: shared transmit slot and shared receive slot
    cfg_write(1'b1, 0, 1'b0, 1'b0, 0, 0, 0, 0, 0);
    cfg_write(1'b0, 1, 1'b1, 1'b1, 4, 0, 2, 4, 0);
    cfg_write(1'b0, 3, 1'b1, 1'b1, 4, 0, 2, 4, 1);
    cfg_write(1'b0, 0, 1'b1, 1'b0, 5, 3, 0, 0, 1);
    m_txb[0] = 8'h3E; m_txb[1] = 8'hC6; m_txb[3] = 8'h19;
    m_rxb[1] = 8'h96; m_rxb[3] = 8'h96;
    run_frame("R9 collision", 1, -1);

    // R10: broadcast ignores the channel field
    cfg_write(1'b1, 2, 1'b1, 1'b1, 9, 2, 9, 5, 1);
    m_txb[0] = 8'hB2; m_txb[1] = 8'h11; m_txb[2] = 8'h22; m_txb[3] = 8'h33;
    for (int c = 0; c < NCH; c++) m_rxb[c] = 8'h4E;
    run_frame("R10 broadcast", 1, -1);

    // R2: long sync pulse does not restart the frame
    cfg_write(1'b1, 0, 1'b0, 1'b0, 0, 0, 0, 0, 0);
    cfg_write(1'b0, 0, 1'b1, 1'b1, 0, 0, 1, 0, 0);
    m_txb[0] = 8'hD9; m_rxb[0] = 8'h2B;
    run_frame("R2 long sync", 4, -1);

    // R12: mid-frame change of transmit data is not sent
    m_txb[0] = 8'hA5; m_rxb[0] = 8'h5C;
    run_frame("R12 latch", 1, 3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule